// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command pins from reset until the memory is ready for normal traffic. After reset it holds the bus idle for a power-up pause of at least 200 µs, measured in clock cycles from a clock-frequency parameter. It then issues the fixed bring-up order:

- one precharge of all banks,
- eight auto-refresh commands,
- one mode-register load that selects the configured CAS latency, a burst length of one and sequential bursts.

After the mode load it waits out the mode-register delay and raises `init_done`. It then marks each periodic refresh slot with a one-clock `refresh_req` strobe, spaced about 15.6 µs apart.

The precharge recovery time and the refresh cycle time come from static configuration inputs, and so does the CAS latency. These inputs must be stable from reset onwards. A controller downstream takes over the command bus once `init_done` is high and uses `refresh_req` to schedule refreshes. While `init_done` is high, this block keeps its own command outputs at NOP.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While reset is asserted, after at least one clock edge, the pins are idle: command NOP, `sd_cke` low, address zero, `init_done` low and `refresh_req` low.
- R2: The command is NOP for WAIT = POWERUP_US·CLK_KHZ/1000 cycles, counted from the first cycle after reset is released (cycles 0 to WAIT-1). `sd_cke` is low in those cycles except the last one, where it rises, and it stays high afterwards.
- R3: In cycle WAIT the command is precharge-all: address bit 10 is 1 and all other address bits are 0.
- R4: After the precharge come exactly `cfg_trp` NOP cycles, and then the first auto-refresh. A value of 0 makes the two commands back to back.
- R5: Exactly eight auto-refresh commands are issued. Each is followed by exactly `cfg_trc` NOP cycles before the next command, and the address is zero during them.
- R6: The ninth command after the precharge is a mode-register load. Its address holds `cfg_cas_lat` in bits 6:4, a 0 in bit 3 (sequential), 000 in bits 2:0 (burst length 1), and zeros above bit 6.
- R7: The mode load is followed by T_MRD NOP cycles (default 3). `init_done` rises in the next cycle and stays high until reset.
- R8: `refresh_req` is a one-cycle pulse that first appears REF cycles after `init_done` rises and then repeats every REF cycles, with REF = floor(156·CLK_KHZ/10000). It is never high while `init_done` is low.
- R9: The commands on {`sd_cs_n`,`sd_ras_n`,`sd_cas_n`,`sd_we_n`} are encoded as NOP=0111, precharge=0010, auto-refresh=0001 and mode load=0000. No other code appears, and while `init_done` is high the code is NOP with the address at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cas_lat | input | 3 | CAS latency to place in the mode word |
| cfg_trp | input | 4 | NOP cycles after precharge-all |
| cfg_trc | input | 4 | NOP cycles after each auto-refresh |
| sd_cke | output | 1 | Clock enable to the SDRAM |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus (A10 for precharge-all, mode word for load) |
| init_done | output | 1 | Bring-up finished, stays high until reset |
| refresh_req | output | 1 | One-cycle strobe at each refresh period |

## Verification
An error in the shared gap counter or in the refresh tally shows up as a command moved by whole cycles. It becomes visible at the pins the same cycle the first misplaced command or NOP appears. Because the reference model predicts every output on every cycle, a shift of even one cycle is caught right there, without waiting for the sequence to end. A wrong refresh-period counter only shows itself at the first expected `refresh_req`, which is REF cycles after `init_done` rises. The bench therefore watches several periods and runs two configurations, one of them with zero-length gaps.

// File: rtl/sdram_seq_pkg.sv
// Package: shared command codes, sequencer states and timing helpers.
// Assumes commands are presented as {cs_n, ras_n, cas_n, we_n}.
package sdram_seq_pkg;

    localparam logic [3:0] CMD_NOP  = 4'b0111;
    localparam logic [3:0] CMD_PALL = 4'b0010;
    localparam logic [3:0] CMD_AREF = 4'b0001;
    localparam logic [3:0] CMD_LMR  = 4'b0000;

    localparam int INIT_REFRESHES = 8;

    typedef enum logic [2:0] {
        ST_PWR,
        ST_PALL,
        ST_PGAP,
        ST_AREF,
        ST_RGAP,
        ST_MODE,
        ST_MGAP,
        ST_RUN
    } seq_state_t;

    // Clock count of the power-up pause.
    function automatic int powerup_clks(input int us, input int khz);
        return (us * khz) / 1000;
    endfunction

    // Clock count of the ~15.6 us refresh period.
    function automatic int refresh_clks(input int khz);
        return (156 * khz) / 10000;
    endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
// Module: loadable down-counter shared by the power-up pause and the
// NOP gaps between bring-up commands. Stops at zero.
// Assumes a load and a decrement never need to happen in the same cycle.
module sdram_gap_timer #(
    parameter int CW      = 16,
    parameter int RST_VAL = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count
);

    // Reload on request, otherwise count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= CW'(RST_VAL);
        else if (load)
            count <= load_val;
        else if (count != '0)
            count <= count - CW'(1);
    end

endmodule

// File: rtl/sdram_refresh_timer.sv
// Module: periodic refresh strobe generator. Held at zero while disabled.
// Once enabled, it pulses 'strobe' for one cycle every PERIOD cycles,
// with the first pulse PERIOD cycles after the enable rises.
// Assumes PERIOD >= 2.
module sdram_refresh_timer #(
    parameter int PERIOD = 3120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic strobe
);

    localparam int RW = $clog2(PERIOD + 1);
    localparam logic [RW-1:0] LAST = RW'(PERIOD - 1);

    logic [RW-1:0] tick_q;

    // Count enabled cycles and fire at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            tick_q <= '0;
            strobe <= 1'b0;
        end else if (tick_q == LAST) begin
            tick_q <= '0;
            strobe <= 1'b1;
        end else begin
            tick_q <= tick_q + RW'(1);
            strobe <= 1'b0;
        end
    end

endmodule

// File: rtl/sdram_init_fsm.sv
// Module: ordered bring-up state machine. It steps through the pause,
// precharge-all, the initial refreshes, the mode load and the mode delay,
// then parks in ST_RUN. Pin values are decoded from the state register
// and the gap counter, which are both flops.
// Assumes the cfg_* inputs are static from reset onwards.
module sdram_init_fsm
    import sdram_seq_pkg::*;
#(
    parameter int CW     = 16,
    parameter int ADDR_W = 13,
    parameter int T_MRD  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_cas_lat,
    input  logic [3:0]        cfg_trp,
    input  logic [3:0]        cfg_trc,
    input  logic [CW-1:0]     gap_count,
    output logic              gap_load,
    output logic [CW-1:0]     gap_val,
    output logic [3:0]        cmd,
    output logic [ADDR_W-1:0] addr,
    output logic              cke,
    output logic              running
);

    localparam int NW = $clog2(INIT_REFRESHES + 1);
    localparam logic [NW-1:0] REF_LAST = NW'(INIT_REFRESHES - 1);
    localparam logic [NW-1:0] REF_ALL  = NW'(INIT_REFRESHES);

    seq_state_t state_q, state_d;
    logic [NW-1:0] refs_q;
    logic gap_end;

    assign gap_end = (gap_count == CW'(1));

    // Next-state and gap-timer load decisions.
    always_comb begin
        state_d  = state_q;
        gap_load = 1'b0;
        gap_val  = '0;
        unique case (state_q)
            ST_PWR:  if (gap_count == '0) state_d = ST_PALL;
            ST_PALL: begin
                gap_load = 1'b1;
                gap_val  = CW'(cfg_trp);
                state_d  = (cfg_trp == 4'd0) ? ST_AREF : ST_PGAP;
            end
            ST_PGAP: if (gap_end) state_d = ST_AREF;
            ST_AREF: begin
                gap_load = 1'b1;
                gap_val  = CW'(cfg_trc);
                if (cfg_trc != 4'd0)      state_d = ST_RGAP;
                else if (refs_q == REF_LAST) state_d = ST_MODE;
                else                      state_d = ST_AREF;
            end
            ST_RGAP: if (gap_end) state_d = (refs_q == REF_ALL) ? ST_MODE : ST_AREF;
            ST_MODE: begin
                gap_load = 1'b1;
                gap_val  = CW'(T_MRD);
                state_d  = (T_MRD == 0) ? ST_RUN : ST_MGAP;
            end
            ST_MGAP: if (gap_end) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PWR;
        else        state_q <= state_d;
    end

    // Tally of refresh commands issued during bring-up.
    always_ff @(posedge clk) begin
        if (!rst_n)                 refs_q <= '0;
        else if (state_q == ST_AREF) refs_q <= refs_q + NW'(1);
    end

    // Pin decode from the current state.
    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        unique case (state_q)
            ST_PALL: begin
                cmd      = CMD_PALL;
                addr[10] = 1'b1;
            end
            ST_AREF: cmd = CMD_AREF;
            ST_MODE: begin
                cmd  = CMD_LMR;
                addr = ADDR_W'({cfg_cas_lat, 1'b0, 3'b000});
            end
            default: ;
        endcase
    end

    // Clock enable rises on the last pause cycle. Running marks normal mode.
    assign cke     = rst_n && ((state_q != ST_PWR) || (gap_count == '0));
    assign running = (state_q == ST_RUN);

endmodule

// File: rtl/sdram_powerup_seq.sv
// Top: SDRAM power-up sequencer. It derives the pause and refresh counts
// from CLK_KHZ, runs the bring-up state machine on a shared gap timer,
// then enables the periodic refresh strobe.
// Assumes ADDR_W >= 11, so that A10 exists.
module sdram_powerup_seq
    import sdram_seq_pkg::*;
#(
    parameter int CLK_KHZ    = 200000,
    parameter int POWERUP_US = 200,
    parameter int ADDR_W     = 13,
    parameter int T_MRD      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_cas_lat,
    input  logic [3:0]        cfg_trp,
    input  logic [3:0]        cfg_trc,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_done,
    output logic              refresh_req
);

    localparam int WAIT_CLKS = powerup_clks(POWERUP_US, CLK_KHZ);
    localparam int REF_CLKS  = refresh_clks(CLK_KHZ);
    localparam int CW        = $clog2(WAIT_CLKS + 16);

    logic [CW-1:0] gap_count, gap_val;
    logic          gap_load;
    logic [3:0]    cmd;

    sdram_gap_timer #(.CW(CW), .RST_VAL(WAIT_CLKS - 1)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .count    (gap_count)
    );

    sdram_init_fsm #(.CW(CW), .ADDR_W(ADDR_W), .T_MRD(T_MRD)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_cas_lat (cfg_cas_lat),
        .cfg_trp     (cfg_trp),
        .cfg_trc     (cfg_trc),
        .gap_count   (gap_count),
        .gap_load    (gap_load),
        .gap_val     (gap_val),
        .cmd         (cmd),
        .addr        (sd_addr),
        .cke         (sd_cke),
        .running     (init_done)
    );

    sdram_refresh_timer #(.PERIOD(REF_CLKS)) u_refresh (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (init_done),
        .strobe (refresh_req)
    );

    // Split the command code onto the individual pins.
    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

endmodule

// File: rtl/sdram_powerup_seq_chk.sv
// Checker: temporal properties of the sequencer pins. It is bound to the top.
module sdram_powerup_seq_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cfg_cas_lat,
    input logic              sd_cke,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic              init_done,
    input logic              refresh_req
);

    logic [3:0] cmd;
    logic [4:0] aref_seen;
    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    // Count refresh commands issued before normal mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                             aref_seen <= '0;
        else if (cmd == 4'b0001 && !init_done) aref_seen <= aref_seen + 5'd1;
    end

    // R9
    legal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 4'b0111 || cmd == 4'b0010 || cmd == 4'b0001 || cmd == 4'b0000);
    // R2
    cke_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_cke |-> cmd == 4'b0111);
    // R3
    pall_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 4'b0010 |-> sd_addr[10]);
    // R5
    eight_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 4'b0000 |-> aref_seen == 5'd8);
    // R6
    mode_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 4'b0000 |-> sd_addr == ADDR_W'({cfg_cas_lat, 4'b0000}));
    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
    // R8
    req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |-> init_done);
    // R8
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |=> !refresh_req);
    // R9
    run_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> cmd == 4'b0111 && sd_addr == '0);

endmodule

bind sdram_powerup_seq sdram_powerup_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_cas_lat (cfg_cas_lat),
    .sd_cke      (sd_cke),
    .sd_cs_n     (sd_cs_n),
    .sd_ras_n    (sd_ras_n),
    .sd_cas_n    (sd_cas_n),
    .sd_we_n     (sd_we_n),
    .sd_addr     (sd_addr),
    .init_done   (init_done),
    .refresh_req (refresh_req)
);

// File: tb/sdram_powerup_seq_tb.sv
`timescale 1ns/1ps
module sdram_powerup_seq_tb;

    localparam int KHZ  = 200000;
    localparam int WAIT = 200 * KHZ / 1000;
    localparam int REFP = 156 * KHZ / 10000;
    localparam int MRD  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] cfg_cas_lat = 3'd3;
    logic [3:0] cfg_trp = 4'd2;
    logic [3:0] cfg_trc = 4'd6;
    logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done, refresh_req;
    logic [12:0] sd_addr;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    sdram_powerup_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_cas_lat(cfg_cas_lat),
        .cfg_trp(cfg_trp), .cfg_trc(cfg_trc), .sd_cke(sd_cke),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_addr(sd_addr), .init_done(init_done),
        .refresh_req(refresh_req)
    );

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Compare all pins against one expected vector.
    task automatic compare(string tag, int c, logic [3:0] ecmd, logic ecke,
                           logic [12:0] eaddr, logic edone, logic ereq);
        logic [3:0] acmd;
        acmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        total++;
        if (acmd !== ecmd || sd_cke !== ecke || sd_addr !== eaddr ||
            init_done !== edone || refresh_req !== ereq) begin
            bad++;
            $display("FAIL %s cycle %0d: got cmd=%b cke=%b addr=%h done=%b req=%b exp cmd=%b cke=%b addr=%h done=%b req=%b",
                     tag, c, acmd, sd_cke, sd_addr, init_done, refresh_req,
                     ecmd, ecke, eaddr, edone, ereq);
        end
    endtask

    // Behavioural reference: expected pins for cycle c after reset release.
    task automatic check_cycle(int c, int cas, int trp, int trc);
        int base, mrs, dn;
        logic [3:0] ecmd;
        logic [12:0] eaddr;
        logic edone, ereq;
        string tag;
        base  = WAIT + 1 + trp;
        mrs   = base + 8 * (trc + 1);
        dn    = mrs + 1 + MRD;
        ecmd  = 4'b0111;
        eaddr = '0;
        edone = 1'b0;
        ereq  = 1'b0;
        if (c < WAIT) tag = "R2";
        else if (c == WAIT) begin
            tag = "R3"; ecmd = 4'b0010; eaddr = 13'h400;
        end else if (c < base) tag = "R4";
        else if (c < mrs) begin
            tag = "R5";
            if ((c - base) % (trc + 1) == 0) ecmd = 4'b0001;
        end else if (c == mrs) begin
            tag = "R6"; ecmd = 4'b0000; eaddr = 13'(cas << 4);
        end else if (c < dn) tag = "R7";
        else begin
            edone = 1'b1;
            if (c > dn && (c - dn) % REFP == 0) begin
                ereq = 1'b1; tag = "R8";
            end else tag = (c == dn) ? "R7" : "R9";
        end
        compare(tag, c, ecmd, (c >= WAIT - 1), eaddr, edone, ereq);
    endtask

    // Reset, then follow one full bring-up plus three refresh periods.
    task automatic run_cfg(int cas, int trp, int trc);
        int last;
        rst_n = 1'b0;
        cfg_cas_lat = 3'(cas);
        cfg_trp = 4'(trp);
        cfg_trc = 4'(trc);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            compare("R1", -1, 4'b0111, 1'b0, 13'h0, 1'b0, 1'b0);
        end
        rst_n = 1'b1;
        last = WAIT + 1 + trp + 8 * (trc + 1) + 1 + MRD + 3 * REFP + 4;
        for (int c = 0; c <= last; c++) begin
            check_cycle(c, cas, trp, trc);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout exp completion");
        summary();
    end

    initial begin
        @(negedge clk);
        run_cfg(3, 2, 6);
        run_cfg(2, 0, 0);
        summary();
    end

endmodule